// File: doc/BRIEF.md
# Fault Status and Alert Register Block

This block keeps the fault and warning state of a hot-swap power controller in a small set of sticky status registers that a serial management bus slave reads and writes. Event inputs from the protection controller and the telemetry sampler are level conditions. Every cycle in which an event is high sets its bits in several registers at once. A summary status word is formed combinationally from the underlying registers. An active-low alert line is driven from every source that is set and not suppressed by the mask register. Masking an event only silences the alert. The status bits still record the event.

After reset the block reports that its settings are at their defaults. A sticky preset bit is set and the alert is asserted until the host issues a clear-faults write. When the first warning or fault arrives, a one-shot snapshot stores the telemetry inputs and the diagnostic bits. Later events do not overwrite the snapshot until the host re-arms it.

The bus slave supplies a write strobe, a write address (the command code) and write data. It also supplies a separate read address and receives read data combinationally.

Top module: `fault_status_alert`

## Requirements
- R1: After reset, alertN is 0. Manufacturer status (80h) reads 0x0001, with the preset flag in bit 0. The status word (79h) reads 0x1000. Input status (7Ch), diagnostic word (E1h), mask (D8h) and snapshot status (C8h) all read 0.
- R2: A high limFault (persistent current or power limit) sets input status bit 4, diagnostic bit 0 and, through input status, status word bit 13.
- R3: A high brkTrip sets manufacturer status bit 1 and diagnostic bit 1.
- R4: A high vinLowWarn sets input status bit 5 and diagnostic bit 2. A high tempHighWarn sets manufacturer status bit 2 and diagnostic bit 3.
- R5: Status word bit 13 is the OR of all input status bits. Status word bit 12 is the OR of all manufacturer status bits. Every other bit of the status word is 0.
- R6: Status bits are sticky. They stay set after the event input returns low.
- R7: A write to command 03h clears every status bit, including the preset flag, at that clock edge. After the clear, alertN is high if no event was present. A condition still high during the clear sets its bits again one cycle later.
- R8: Mask register D8h holds 5 bits, one per alert source: bit 0 preset, bit 1 limFault, bit 2 brkTrip, bit 3 vinLowWarn, bit 4 tempHighWarn. alertN is low exactly when some set status source has a clear mask bit. Masked sources still appear in the status registers.
- R9: While the snapshot is armed (it is armed at reset), the first cycle in which any event input is high captures the telemetry channels and the diagnostic bits including that cycle's events. Channel i reads at C0h+i, zero-extended. C8h reads {valid in bit 15, diagnostic in bits 7:0}.
- R10: A captured snapshot is not changed by later events or by clear-faults.
- R11: A write to C8h clears the valid flag and re-arms the snapshot, so the next event captures again.
- R12: Writes to status registers are ignored. Reads of undefined addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| limFault | input | 1 | Persistent current/power limit fault condition |
| brkTrip | input | 1 | Circuit breaker trip condition |
| vinLowWarn | input | 1 | Input undervoltage warning condition |
| tempHighWarn | input | 1 | Overtemperature warning condition |
| telemetry | input | NTEL*TEL_W | Live telemetry channels, channel 0 in the low bits |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Write command code |
| wrData | input | DATA_W | Write data |
| rdAddr | input | 8 | Read command code |
| rdData | output | DATA_W | Read data |
| alertN | output | 1 | Active-low alert |

## Verification
The hardest situation to reach is a clear-faults write landing while a condition is still present. The stimulus holds the undervoltage warning high across the write. It then reads the input status in the cycle right after the clear and again one cycle later, to show the clear winning and then the bit re-setting. Snapshot retention is shown differently. The first event of a 16-combination sweep is the capture. The sweep then runs the remaining combinations and clear-faults writes over it, and the bench compares the snapshot against the telemetry of that first event before it re-arms. Every event combination is crossed with all 32 mask values to check the alert.

// File: rtl/fault_status_pkg.sv
package fault_status_pkg;
  localparam logic [7:0] CMD_CLEAR     = 8'h03;
  localparam logic [7:0] CMD_WORD      = 8'h79;
  localparam logic [7:0] CMD_INPUT     = 8'h7C;
  localparam logic [7:0] CMD_MFR       = 8'h80;
  localparam logic [7:0] CMD_MASK      = 8'hD8;
  localparam logic [7:0] CMD_DIAG      = 8'hE1;
  localparam logic [7:0] CMD_SNAP_TEL  = 8'hC0;
  localparam logic [7:0] CMD_SNAP_STAT = 8'hC8;

  localparam int NUM_SRC = 5;

  typedef struct packed {
    logic clrAll;
    logic maskWr;
    logic rearm;
    logic capture;
  } ctlStrobe_t;
endpackage

// File: rtl/status_ctrl.sv
module status_ctrl
  import fault_status_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrAddr,
  input  logic       anyEvt,
  output ctlStrobe_t strb
);
  logic armed;

  always_comb begin
    strb.clrAll  = wrEn && (wrAddr == CMD_CLEAR);
    strb.maskWr  = wrEn && (wrAddr == CMD_MASK);
    strb.rearm   = wrEn && (wrAddr == CMD_SNAP_STAT);
    strb.capture = armed && anyEvt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             armed <= 1'b1;
    else if (strb.rearm)   armed <= 1'b1;
    else if (strb.capture) armed <= 1'b0;
  end
endmodule

// File: rtl/status_regs.sv
module status_regs
  import fault_status_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TEL_W  = 12,
  parameter int NTEL   = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  limFault,
  input  logic                  brkTrip,
  input  logic                  vinLowWarn,
  input  logic                  tempHighWarn,
  input  logic [NTEL*TEL_W-1:0] telemetry,
  input  ctlStrobe_t            strb,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [7:0]            rdAddr,
  output logic [DATA_W-1:0]     rdData,
  output logic                  alertN,
  output logic [7:0]            inStatQ,
  output logic [7:0]            mfrStatQ,
  output logic [7:0]            diagQ,
  output logic [7:0]            maskQ,
  output logic                  snapValidQ,
  output logic [7:0]            snapDiagQ
);
  localparam int PAD_W = DATA_W - TEL_W;

  logic [7:0] inSet, mfrSet, diagSet;
  logic [DATA_W-1:0] statusWord;
  logic [NUM_SRC-1:0] srcVec;
  logic [TEL_W-1:0] snapTel [NTEL];

  always_comb begin
    inSet   = {2'b00, vinLowWarn, limFault, 4'b0000};
    mfrSet  = {5'b00000, tempHighWarn, brkTrip, 1'b0};
    diagSet = {4'b0000, tempHighWarn, vinLowWarn, brkTrip, limFault};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inStatQ  <= '0;
      mfrStatQ <= 8'h01;
      diagQ    <= '0;
    end else if (strb.clrAll) begin
      inStatQ  <= '0;
      mfrStatQ <= '0;
      diagQ    <= '0;
    end else begin
      inStatQ  <= inStatQ | inSet;
      mfrStatQ <= mfrStatQ | mfrSet;
      diagQ    <= diagQ | diagSet;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            maskQ <= '0;
    else if (strb.maskWr) maskQ <= {3'b000, wrData[NUM_SRC-1:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapValidQ <= 1'b0;
      snapDiagQ  <= '0;
    end else if (strb.capture) begin
      snapValidQ <= 1'b1;
      snapDiagQ  <= diagQ | diagSet;
    end else if (strb.rearm) begin
      snapValidQ <= 1'b0;
    end
  end

  for (genvar ch = 0; ch < NTEL; ch++) begin : gSnap
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             snapTel[ch] <= '0;
      else if (strb.capture) snapTel[ch] <= telemetry[ch*TEL_W +: TEL_W];
    end
  end

  always_comb begin
    srcVec = {mfrStatQ[2], inStatQ[5], mfrStatQ[1], inStatQ[4], mfrStatQ[0]};
    alertN = ~|(srcVec & ~maskQ[NUM_SRC-1:0]);
    statusWord = '0;
    statusWord[13] = |inStatQ;
    statusWord[12] = |mfrStatQ;
  end

  always_comb begin
    rdData = '0;
    unique case (rdAddr)
      CMD_WORD:      rdData = statusWord;
      CMD_INPUT:     rdData = {{(DATA_W-8){1'b0}}, inStatQ};
      CMD_MFR:       rdData = {{(DATA_W-8){1'b0}}, mfrStatQ};
      CMD_MASK:      rdData = {{(DATA_W-8){1'b0}}, maskQ};
      CMD_DIAG:      rdData = {{(DATA_W-8){1'b0}}, diagQ};
      CMD_SNAP_STAT: rdData = {snapValidQ, {(DATA_W-9){1'b0}}, snapDiagQ};
      default: begin
        for (int ch = 0; ch < NTEL; ch++) begin
          if (rdAddr == CMD_SNAP_TEL + 8'(ch)) rdData = {{PAD_W{1'b0}}, snapTel[ch]};
        end
      end
    endcase
  end
endmodule

// File: rtl/fault_status_alert.sv
module fault_status_alert
  import fault_status_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TEL_W  = 12,
  parameter int NTEL   = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  limFault,
  input  logic                  brkTrip,
  input  logic                  vinLowWarn,
  input  logic                  tempHighWarn,
  input  logic [NTEL*TEL_W-1:0] telemetry,
  input  logic                  wrEn,
  input  logic [7:0]            wrAddr,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [7:0]            rdAddr,
  output logic [DATA_W-1:0]     rdData,
  output logic                  alertN
);
  ctlStrobe_t strb;
  logic [7:0] inStatQ, mfrStatQ, diagQ, maskQ, snapDiagQ;
  logic snapValidQ;
  logic anyEvt;

  assign anyEvt = limFault | brkTrip | vinLowWarn | tempHighWarn;

  status_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .anyEvt(anyEvt), .strb(strb)
  );

  status_regs #(.DATA_W(DATA_W), .TEL_W(TEL_W), .NTEL(NTEL)) u_regs (
    .clk(clk), .rstN(rstN), .limFault(limFault), .brkTrip(brkTrip),
    .vinLowWarn(vinLowWarn), .tempHighWarn(tempHighWarn),
    .telemetry(telemetry), .strb(strb), .wrData(wrData), .rdAddr(rdAddr),
    .rdData(rdData), .alertN(alertN), .inStatQ(inStatQ),
    .mfrStatQ(mfrStatQ), .diagQ(diagQ), .maskQ(maskQ),
    .snapValidQ(snapValidQ), .snapDiagQ(snapDiagQ)
  );
endmodule

// File: rtl/fault_status_alert_chk.sv
module fault_status_alert_chk (
  input logic       clk,
  input logic       rstN,
  input logic       limFault,
  input logic       brkTrip,
  input logic       vinLowWarn,
  input logic       tempHighWarn,
  input logic       wrEn,
  input logic [7:0] wrAddr,
  input logic       alertN,
  input logic [7:0] inStatQ,
  input logic [7:0] mfrStatQ,
  input logic [7:0] diagQ,
  input logic [7:0] maskQ,
  input logic       snapValidQ,
  input logic [7:0] snapDiagQ
);
  logic clrW, rearmW, evtAny;
  assign clrW   = wrEn && (wrAddr == 8'h03);
  assign rearmW = wrEn && (wrAddr == 8'hC8);
  assign evtAny = limFault | brkTrip | vinLowWarn | tempHighWarn;

  // R2
  oc_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (limFault && !clrW) |=> (inStatQ[4] && diagQ[0]));
  // R3
  brk_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brkTrip && !clrW) |=> (mfrStatQ[1] && diagQ[1]));
  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clrW |=> ((diagQ & $past(diagQ)) == $past(diagQ)));
  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrW |=> (inStatQ == 8'h00 && mfrStatQ == 8'h00 && diagQ == 8'h00));
  // R7
  clear_alert_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrW && !evtAny) |=> alertN);
  // R8
  full_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ[4:0] == 5'h1F) |-> alertN);
  // R10
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (snapValidQ && !rearmW) |=> (snapValidQ && $stable(snapDiagQ)));
endmodule

bind fault_status_alert fault_status_alert_chk u_chk (
  .clk(clk), .rstN(rstN), .limFault(limFault), .brkTrip(brkTrip),
  .vinLowWarn(vinLowWarn), .tempHighWarn(tempHighWarn), .wrEn(wrEn),
  .wrAddr(wrAddr), .alertN(alertN), .inStatQ(inStatQ), .mfrStatQ(mfrStatQ),
  .diagQ(diagQ), .maskQ(maskQ), .snapValidQ(snapValidQ), .snapDiagQ(snapDiagQ)
);

// File: tb/fault_status_alert_tb.sv
`timescale 1ns/1ps
module fault_status_alert_tb;
  localparam int DATA_W = 16;
  localparam int TEL_W  = 12;
  localparam int NTEL   = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic limFault = 0, brkTrip = 0, vinLowWarn = 0, tempHighWarn = 0;
  logic [NTEL*TEL_W-1:0] telemetry = '0;
  logic wrEn = 0;
  logic [7:0] wrAddr = '0, rdAddr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic alertN;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fault_status_alert #(.DATA_W(DATA_W), .TEL_W(TEL_W), .NTEL(NTEL)) u_dut (
    .clk(clk), .rstN(rstN), .limFault(limFault), .brkTrip(brkTrip),
    .vinLowWarn(vinLowWarn), .tempHighWarn(tempHighWarn),
    .telemetry(telemetry), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .alertN(alertN)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [7:0] a, input logic [DATA_W-1:0] exp);
    rdAddr = a;
    #1;
    check(req, 32'(rdData), 32'(exp));
  endtask

  task automatic setTel(input int base);
    for (int i = 0; i < NTEL; i++) telemetry[i*TEL_W +: TEL_W] = TEL_W'(base + i);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] eIn, eMfr, eDiag;
    logic [4:0] src;
    logic [DATA_W-1:0] eWord;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 alert", 32'(alertN), 0);
    rdChk("R1 mfr", 8'h80, 16'h0001);
    rdChk("R1 word", 8'h79, 16'h1000);
    rdChk("R1 input", 8'h7C, 0);
    rdChk("R1 diag", 8'hE1, 0);
    rdChk("R1 mask", 8'hD8, 0);
    rdChk("R1 snap", 8'hC8, 0);

    // R12 writes to status registers ignored, undefined reads are zero
    wr(8'h7C, 16'h00FF);
    wr(8'hE1, 16'h00FF);
    rdChk("R12 input ro", 8'h7C, 0);
    rdChk("R12 diag ro", 8'hE1, 0);
    rdChk("R12 undefined", 8'h55, 0);

    // Sweep all event combinations (R2 R3 R4 R5 R6 R8); first event fires the snapshot (R9)
    for (int c = 0; c < 16; c++) begin
      wr(8'h03, 0);
      setTel(c * 16 + 1);
      @(negedge clk);
      limFault = c[0]; brkTrip = c[1]; vinLowWarn = c[2]; tempHighWarn = c[3];
      @(negedge clk);
      limFault = 0; brkTrip = 0; vinLowWarn = 0; tempHighWarn = 0;
      @(negedge clk);
      eIn   = {2'b00, c[2], c[0], 4'b0000};
      eMfr  = {5'b00000, c[3], c[1], 1'b0};
      eDiag = {4'b0000, c[3], c[2], c[1], c[0]};
      eWord = '0;
      eWord[13] = |eIn;
      eWord[12] = |eMfr;
      rdChk("R2 R4 R6 input", 8'h7C, {8'h00, eIn});
      rdChk("R3 R4 R6 mfr", 8'h80, {8'h00, eMfr});
      rdChk("R2 R3 R4 diag", 8'hE1, {8'h00, eDiag});
      rdChk("R5 word", 8'h79, eWord);
      src = {c[3], c[2], c[1], c[0], 1'b0};
      for (int m = 0; m < 32; m++) begin
        wr(8'hD8, DATA_W'(m));
        check("R8 alert", 32'(alertN), 32'(~|(src & ~5'(m))));
      end
      rdChk("R8 status kept", 8'hE1, {8'h00, eDiag});
      wr(8'hD8, 0);
    end

    // R9 R10 snapshot from combo 1 retained through later events and clears
    rdChk("R9 R10 snap stat", 8'hC8, 16'h8001);
    for (int i = 0; i < NTEL; i++)
      rdChk("R9 R10 snap tel", 8'hC0 + 8'(i), DATA_W'(16 + 1 + i));

    // R11 re-arm and capture again
    wr(8'h03, 0);
    wr(8'hC8, 0);
    rdChk("R11 valid cleared", 8'hC8, 16'h0001);
    setTel(256);
    @(negedge clk);
    brkTrip = 1;
    @(negedge clk);
    brkTrip = 0;
    setTel(512);
    @(negedge clk);
    rdChk("R11 snap stat", 8'hC8, 16'h8002);
    for (int i = 0; i < NTEL; i++)
      rdChk("R11 snap tel", 8'hC0 + 8'(i), DATA_W'(256 + i));

    // R7 clear with no condition deasserts alert; clear with condition held re-sets
    wr(8'h03, 0);
    check("R7 alert after clear", 32'(alertN), 1);
    rdChk("R7 preset cleared", 8'h80, 0);
    @(negedge clk);
    vinLowWarn = 1;
    @(negedge clk);
    rdAddr = 8'h7C;
    wr(8'h03, 0);
    rdChk("R7 cleared edge", 8'h7C, 0);
    @(negedge clk);
    rdChk("R7 re-set", 8'h7C, 16'h0020);
    check("R7 alert re-asserted", 32'(alertN), 0);
    vinLowWarn = 0;
    wr(8'h03, 0);
    check("R7 final alert", 32'(alertN), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule